// File: doc/BRIEF.md
# Single-Line Write-Update Snoop Controller

This block keeps one cached line coherent under a write-back snooping protocol that updates peers rather than invalidating them. Dirty data is never held in two caches at once. A resident line is exclusive-clean, shared-clean or modified-exclusive, or no line is held at all. The processor side takes read and write requests through a valid/ready handshake and answers each one with a hit flag and data. The bus side does three things: it issues line fills, update broadcasts and write-backs; it watches other masters' transactions; and it drives a wired "copy held here" signal.

Each bus transaction ends when the bus pulses an acknowledge. The controller samples the wired shared signal with that acknowledge and uses it to choose the line's next state. A write to a shared line goes out as an update broadcast that refreshes memory and every peer copy. If no peer claims the line at that point, the line falls back to exclusive. A snooped read of a modified line makes this cache supply the data and flag a memory update, and the line becomes shared. Snooped transactions take precedence over new processor requests. The bus must present no snoop while this controller owns the bus.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset no line is resident. The outputs cpu_resp_valid, bus_req_valid and snp_shared_out are low, cpu_req_ready is high, and a snoop to any address, including address 0, gets no shared answer.
- R2: A read miss issues a bus command of code 1 (fill) to the aligned address. One cycle after the acknowledge, the response shows hit=0 and the acknowledged bus data. The line becomes shared if bus_shared_in was high at the acknowledge, and exclusive otherwise.
- R3: A read hit answers one cycle after acceptance with hit=1 and the stored data, and issues no bus command.
- R4: A write hit on an exclusive or modified line issues no bus command, stores the data and leaves the line modified. It answers one cycle after acceptance with hit=1 and the written data.
- R5: A write hit on a shared line issues command code 2 (update) carrying the address and the new data. Afterwards the line stays shared if bus_shared_in was high at the acknowledge, and becomes exclusive otherwise. The response has hit=1.
- R6: A write miss issues command code 2 (update) carrying the data. The line ends shared if bus_shared_in was high at the acknowledge, and modified otherwise. The response has hit=0.
- R7: A miss that would displace a modified line first issues command code 3 (write-back) with the victim's aligned address and data. Only then does it issue the fill or update.
- R8: snp_shared_out is high in the same cycle as snp_valid exactly when the snooped aligned address matches a resident line. A non-matching snoop changes nothing.
- R9: A snooped read (snp_is_update=0) that hits a modified line raises snp_supply and snp_mem_upd in the same cycle, with snp_supply_data equal to the line's data. All other snoops leave both low.
- R10: Any matching snoop leaves the line shared. A matching update snoop (snp_is_update=1) replaces the stored data with snp_wdata.
- R11: cpu_req_ready is low while snp_valid is high, and from acceptance of a bus-bound request until its response. A request held during a snoop is not taken.
- R12: Addresses that differ only in their low OFS_W bits (2 by default) refer to the same line. Bus addresses carry those bits as zero.
- R13: While bus_req_valid waits for bus_ack, the command, address and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request taken this cycle if valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_hit | output | 1 | Request hit the resident line |
| cpu_resp_rdata | output | DATA_W | Read data, or the written data for writes |
| bus_req_valid | output | 1 | Bus transaction outstanding |
| bus_req_cmd | output | 2 | 1 fill, 2 update, 3 write-back, 0 none |
| bus_req_addr | output | ADDR_W | Aligned transaction address |
| bus_req_wdata | output | DATA_W | Update or write-back data |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_shared_in | input | 1 | Wired shared signal, sampled with bus_ack |
| bus_rdata | input | DATA_W | Fill data, valid with bus_ack |
| snp_valid | input | 1 | Another master's transaction is visible |
| snp_is_update | input | 1 | 1 = update broadcast, 0 = read |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped update data |
| snp_shared_out | output | 1 | Drive onto the wired shared signal |
| snp_supply | output | 1 | This cache supplies the snooped read data |
| snp_supply_data | output | DATA_W | Supplied data |
| snp_mem_upd | output | 1 | Memory must capture the supplied data |

## Verification
Snoop answers are combinational, so the bench checks them one time unit after it drives the snoop, in the same cycle. A hit that needs no bus answers in the cycle after the accepting edge. A bus-bound request raises bus_req_valid in that same following cycle. Its response, or the next transaction after a write-back, appears in the cycle after the acknowledging edge. The bench samples at every falling edge and requires exactly one of those outcomes at each one, so a late or extra transaction is reported. State changes are not visible directly; the bench infers them from later requests and compares them against its own line model.

// File: rtl/ucoh_pkg.sv
// Shared types for the write-update snoop controller.
// Assumes a one-word line; encodings are fixed because bus ports carry them.
package ucoh_pkg;
    typedef enum logic [1:0] {
        LN_INV   = 2'd0,
        LN_EXCL  = 2'd1,
        LN_SHRD  = 2'd2,
        LN_DIRTY = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_READ  = 2'd1,
        BC_UPDT  = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_EVICT = 2'd1,
        C_XFER  = 2'd2
    } ctl_fsm_e;
endpackage

// File: rtl/ucoh_line_store.sv
// Holds the tag, data and coherence state of the single modelled line.
// Two write ports: snoop updates win over controller updates. The bus
// protocol keeps the two ports from being active in the same cycle.
module ucoh_line_store
    import ucoh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_we,
    input  line_st_e          snp_st,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              ctl_we,
    input  logic [ADDR_W-1:0] ctl_tag,
    input  line_st_e          ctl_st,
    input  logic [DATA_W-1:0] ctl_data,
    output line_st_e          ln_st,
    output logic [ADDR_W-1:0] ln_tag,
    output logic [DATA_W-1:0] ln_data
);
    // Line register with snoop-first write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ln_st   <= LN_INV;
            ln_tag  <= '0;
            ln_data <= '0;
        end else if (snp_we) begin
            ln_st   <= snp_st;
            ln_data <= snp_data;
        end else if (ctl_we) begin
            ln_st   <= ctl_st;
            ln_tag  <= ctl_tag;
            ln_data <= ctl_data;
        end
    end
endmodule

// File: rtl/ucoh_snoop_unit.sv
// Combinational snoop responder: compares the snooped aligned address with
// the resident line, drives the shared answer, supplies modified data on a
// snooped read, and produces the line update that the snoop implies.
module ucoh_snoop_unit
    import ucoh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic              snp_valid,
    input  logic              snp_is_update,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_wdata,
    input  line_st_e          ln_st,
    input  logic [ADDR_W-1:0] ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              snp_shared_out,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_supply_data,
    output logic              snp_mem_upd,
    output logic              upd_we,
    output line_st_e          upd_st,
    output logic [DATA_W-1:0] upd_data
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

    logic match;

    // Address match and all snoop-side answers.
    always_comb begin
        match           = snp_valid && (ln_st != LN_INV) && ((snp_addr & ALIGN_MASK) == ln_tag);
        snp_shared_out  = match;
        snp_supply      = match && !snp_is_update && (ln_st == LN_DIRTY);
        snp_mem_upd     = snp_supply;
        snp_supply_data = snp_supply ? ln_data : '0;
        upd_we          = match;
        upd_st          = LN_SHRD;
        upd_data        = snp_is_update ? snp_wdata : ln_data;
    end
endmodule

// File: rtl/ucoh_proc_ctrl.sv
// Processor-side sequencer: accepts requests, resolves hits locally, and
// runs write-back, fill and update transactions on the bus. Requests are
// refused while a snoop is present or a transaction is outstanding.
// Assumes no snoop arrives while this controller owns the bus.
module ucoh_proc_ctrl
    import ucoh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_ack,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snoop_active,
    input  line_st_e          ln_st,
    input  logic [ADDR_W-1:0] ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              ctl_we,
    output logic [ADDR_W-1:0] ctl_tag,
    output line_st_e          ctl_st,
    output logic [DATA_W-1:0] ctl_data
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

    ctl_fsm_e          fsm;
    logic              op_write;
    logic              op_hit;
    logic [ADDR_W-1:0] op_tag;
    logic [DATA_W-1:0] op_wdata;
    logic [ADDR_W-1:0] req_tag;
    logic              req_hit;
    logic              accept;

    // Request decode and handshake.
    always_comb begin
        req_tag       = cpu_req_addr & ALIGN_MASK;
        req_hit       = (ln_st != LN_INV) && (ln_tag == req_tag);
        cpu_req_ready = (fsm == C_IDLE) && !snoop_active;
        accept        = cpu_req_valid && cpu_req_ready;
    end

    // Bus request outputs, derived from registered state only.
    always_comb begin
        bus_req_valid = (fsm != C_IDLE);
        bus_req_cmd   = BC_NONE;
        bus_req_addr  = '0;
        bus_req_wdata = '0;
        if (fsm == C_EVICT) begin
            bus_req_cmd   = BC_WBACK;
            bus_req_addr  = ln_tag;
            bus_req_wdata = ln_data;
        end else if (fsm == C_XFER) begin
            bus_req_cmd   = op_write ? BC_UPDT : BC_READ;
            bus_req_addr  = op_tag;
            bus_req_wdata = op_write ? op_wdata : '0;
        end
    end

    // Line updates requested by the processor side.
    always_comb begin
        ctl_we   = 1'b0;
        ctl_tag  = ln_tag;
        ctl_st   = ln_st;
        ctl_data = ln_data;
        unique case (fsm)
            C_IDLE: begin
                if (accept && req_hit && cpu_req_write) begin
                    ctl_we   = 1'b1;
                    ctl_data = cpu_req_wdata;
                    ctl_st   = (ln_st == LN_SHRD) ? LN_SHRD : LN_DIRTY;
                end
            end
            C_EVICT: begin
                if (bus_ack) begin
                    ctl_we = 1'b1;
                    ctl_st = LN_INV;
                end
            end
            C_XFER: begin
                if (bus_ack) begin
                    ctl_we  = 1'b1;
                    ctl_tag = op_tag;
                    if (!op_write) begin
                        ctl_data = bus_rdata;
                        ctl_st   = bus_shared_in ? LN_SHRD : LN_EXCL;
                    end else if (op_hit) begin
                        ctl_data = op_wdata;
                        ctl_st   = bus_shared_in ? LN_SHRD : LN_EXCL;
                    end else begin
                        ctl_data = op_wdata;
                        ctl_st   = bus_shared_in ? LN_SHRD : LN_DIRTY;
                    end
                end
            end
            default: ;
        endcase
    end

    // Sequencer state, captured request and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm            <= C_IDLE;
            op_write       <= 1'b0;
            op_hit         <= 1'b0;
            op_tag         <= '0;
            op_wdata       <= '0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_hit   <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            cpu_resp_valid <= 1'b0;
            unique case (fsm)
                C_IDLE: begin
                    if (accept) begin
                        op_write <= cpu_req_write;
                        op_hit   <= req_hit;
                        op_tag   <= req_tag;
                        op_wdata <= cpu_req_wdata;
                        if (req_hit && !(cpu_req_write && ln_st == LN_SHRD)) begin
                            cpu_resp_valid <= 1'b1;
                            cpu_resp_hit   <= 1'b1;
                            cpu_resp_rdata <= cpu_req_write ? cpu_req_wdata : ln_data;
                        end else if (!req_hit && ln_st == LN_DIRTY) begin
                            fsm <= C_EVICT;
                        end else begin
                            fsm <= C_XFER;
                        end
                    end
                end
                C_EVICT: begin
                    if (bus_ack) fsm <= C_XFER;
                end
                C_XFER: begin
                    if (bus_ack) begin
                        cpu_resp_valid <= 1'b1;
                        cpu_resp_hit   <= op_hit;
                        cpu_resp_rdata <= op_write ? op_wdata : bus_rdata;
                        fsm            <= C_IDLE;
                    end
                end
                default: fsm <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/upd_coh_ctrl.sv
// Top of the single-line write-update snoop controller: joins the line
// store, the snoop responder and the processor-side sequencer.
// Assumes the bus never shows a snoop while this block owns the bus.
module upd_coh_ctrl
    import ucoh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_ack,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_is_update,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_wdata,
    output logic              snp_shared_out,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_supply_data,
    output logic              snp_mem_upd
);
    line_st_e          ln_st;
    logic [ADDR_W-1:0] ln_tag;
    logic [DATA_W-1:0] ln_data;
    logic              s_we;
    line_st_e          s_st;
    logic [DATA_W-1:0] s_data;
    logic              c_we;
    logic [ADDR_W-1:0] c_tag;
    line_st_e          c_st;
    logic [DATA_W-1:0] c_data;

    ucoh_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .snp_we(s_we), .snp_st(s_st), .snp_data(s_data),
        .ctl_we(c_we), .ctl_tag(c_tag), .ctl_st(c_st), .ctl_data(c_data),
        .ln_st(ln_st), .ln_tag(ln_tag), .ln_data(ln_data)
    );

    ucoh_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_snoop (
        .snp_valid(snp_valid), .snp_is_update(snp_is_update),
        .snp_addr(snp_addr), .snp_wdata(snp_wdata),
        .ln_st(ln_st), .ln_tag(ln_tag), .ln_data(ln_data),
        .snp_shared_out(snp_shared_out), .snp_supply(snp_supply),
        .snp_supply_data(snp_supply_data), .snp_mem_upd(snp_mem_upd),
        .upd_we(s_we), .upd_st(s_st), .upd_data(s_data)
    );

    ucoh_proc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit),
        .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_ack(bus_ack), .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
        .snoop_active(snp_valid),
        .ln_st(ln_st), .ln_tag(ln_tag), .ln_data(ln_data),
        .ctl_we(c_we), .ctl_tag(c_tag), .ctl_st(c_st), .ctl_data(c_data)
    );
endmodule

// File: rtl/ucoh_ctrl_chk.sv
// Protocol checker for upd_coh_ctrl, attached through bind below.
// Observes ports only; holds no state of its own.
module ucoh_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_ready,
    input logic              cpu_resp_valid,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic [DATA_W-1:0] bus_req_wdata,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic              snp_is_update,
    input logic              snp_shared_out,
    input logic              snp_supply,
    input logic              snp_mem_upd
);
    AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_req_ready); // R11
    AST_BUS_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !cpu_req_ready); // R11
    AST_BUS_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_ack) |=> (bus_req_valid && $stable(bus_req_cmd)
            && $stable(bus_req_addr) && $stable(bus_req_wdata))); // R13
    AST_SHARED_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared_out |-> snp_valid); // R8
    AST_SUPPLY_IS_SHARED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_shared_out && !snp_is_update)); // R9
    AST_MEMUPD_WITH_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_mem_upd |-> snp_supply); // R9
    AST_WBACK_THEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_ack && bus_req_cmd == 2'd3)
            |=> (bus_req_valid && bus_req_cmd != 2'd3)); // R7
    AST_ACK_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_ack && bus_req_cmd != 2'd3) |=> cpu_resp_valid); // R2
endmodule

bind upd_coh_ctrl ucoh_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready),
    .cpu_resp_valid(cpu_resp_valid), .bus_req_valid(bus_req_valid),
    .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_ack(bus_ack), .snp_valid(snp_valid),
    .snp_is_update(snp_is_update), .snp_shared_out(snp_shared_out),
    .snp_supply(snp_supply), .snp_mem_upd(snp_mem_upd)
);

// File: tb/upd_coh_ctrl_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared against a bench-side model of the line.
module upd_coh_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_resp_valid;
    logic          cpu_resp_hit;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_wdata;
    logic          bus_ack = 1'b0;
    logic          bus_shared_in = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic          snp_is_update = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_wdata = '0;
    logic          snp_shared_out;
    logic          snp_supply;
    logic [DW-1:0] snp_supply_data;
    logic          snp_mem_upd;

    always #5 clk = ~clk;

    upd_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(2)) u_dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench line model: 0 none, 1 exclusive, 2 shared, 3 modified.
    int            m_st = 0;
    logic [AW-1:0] m_tag = '0;
    logic [DW-1:0] m_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
        return a & ~16'h0003;
    endfunction

    // One processor request, serving every bus transaction it raises.
    task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit sh, input int dly, input string req);
        logic [1:0]    e_cmd[2];
        logic [AW-1:0] e_adr[2];
        logic [DW-1:0] e_dat[2];
        int            e_n = 0;
        int            idx = 0;
        bit            hit;
        logic [DW-1:0] fill = '0;
        bit            got = 1'b0;
        hit = (m_st != 0) && (m_tag == align(a));
        if (!hit && m_st == 3) begin
            e_cmd[e_n] = 2'd3; e_adr[e_n] = m_tag; e_dat[e_n] = m_data; e_n++;
        end
        if (!hit) begin
            e_cmd[e_n] = wr ? 2'd2 : 2'd1; e_adr[e_n] = align(a); e_dat[e_n] = d; e_n++;
        end else if (wr && m_st == 2) begin
            e_cmd[e_n] = 2'd2; e_adr[e_n] = align(a); e_dat[e_n] = d; e_n++;
        end
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        #1;
        chk(cpu_req_ready == 1'b1, "R11", "ready when idle", 64'(cpu_req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int cyc = 0; cyc < 20 && !got; cyc++) begin
            if (cpu_resp_valid) begin
                got = 1'b1;
            end else if (bus_req_valid) begin
                if (idx < e_n) begin
                    chk(bus_req_cmd == e_cmd[idx], req, "bus cmd", 64'(bus_req_cmd), 64'(e_cmd[idx]));
                    chk(bus_req_addr == e_adr[idx], "R12", "bus addr", 64'(bus_req_addr), 64'(e_adr[idx]));
                    if (e_cmd[idx] != 2'd1)
                        chk(bus_req_wdata == e_dat[idx], req, "bus data", 64'(bus_req_wdata), 64'(e_dat[idx]));
                end else begin
                    chk(1'b0, req, "extra bus transaction", 64'(bus_req_cmd), 64'd0);
                end
                chk(cpu_req_ready == 1'b0, "R11", "ready during bus op", 64'(cpu_req_ready), 64'd0);
                for (int k = 0; k < dly; k++) begin
                    logic [1:0]    c0 = bus_req_cmd;
                    logic [AW-1:0] a0 = bus_req_addr;
                    logic [DW-1:0] d0 = bus_req_wdata;
                    @(posedge clk);
                    @(negedge clk);
                    chk(bus_req_valid && bus_req_cmd == c0 && bus_req_addr == a0 && bus_req_wdata == d0,
                        "R13", "request held", 64'(bus_req_addr), 64'(a0));
                end
                fill = $urandom;
                bus_ack = 1'b1; bus_shared_in = sh; bus_rdata = fill;
                @(posedge clk);
                @(negedge clk);
                bus_ack = 1'b0; bus_shared_in = 1'b0;
                idx++;
            end else begin
                chk(1'b0, req, "no response and no bus op", 64'd0, 64'd1);
                @(posedge clk);
                @(negedge clk);
            end
        end
        chk(got, req, "response seen", 64'(got), 64'd1);
        chk(idx == e_n, req, "bus transaction count", 64'(idx), 64'(e_n));
        chk(cpu_resp_hit == hit, req, "hit flag", 64'(cpu_resp_hit), 64'(hit));
        if (wr)
            chk(cpu_resp_rdata == d, req, "write echo", 64'(cpu_resp_rdata), 64'(d));
        else
            chk(cpu_resp_rdata == (hit ? m_data : fill), req, "read data",
                64'(cpu_resp_rdata), 64'(hit ? m_data : fill));
        if (hit && !wr) begin
        end else if (hit && wr) begin
            m_st = (m_st == 2) ? (sh ? 2 : 1) : 3;
            m_data = d;
        end else if (!wr) begin
            m_tag = align(a); m_data = fill; m_st = sh ? 2 : 1;
        end else begin
            m_tag = align(a); m_data = d; m_st = sh ? 2 : 3;
        end
    endtask

    // One snoop; optionally a processor request collides with it.
    task automatic snoop_op(input bit upd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit collide);
        bit hit;
        bit sup;
        hit = (m_st != 0) && (m_tag == align(a));
        sup = hit && !upd && (m_st == 3);
        @(negedge clk);
        snp_valid = 1'b1; snp_is_update = upd; snp_addr = a; snp_wdata = d;
        if (collide) begin
            cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = a; cpu_req_wdata = ~d;
        end
        #1;
        chk(snp_shared_out == hit, "R8", "shared answer", 64'(snp_shared_out), 64'(hit));
        chk(snp_supply == sup, "R9", "supply", 64'(snp_supply), 64'(sup));
        chk(snp_mem_upd == sup, "R9", "memory update flag", 64'(snp_mem_upd), 64'(sup));
        if (sup)
            chk(snp_supply_data == m_data, "R9", "supplied data", 64'(snp_supply_data), 64'(m_data));
        chk(cpu_req_ready == 1'b0, "R11", "ready during snoop", 64'(cpu_req_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
        if (collide) begin
            cpu_req_valid = 1'b0;
            chk(!cpu_resp_valid && !bus_req_valid, "R11", "colliding request not taken",
                64'({cpu_resp_valid, bus_req_valid}), 64'd0);
        end
        if (hit) begin
            m_st = 2;
            if (upd) m_data = d;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs and no resident line after reset
        chk(!cpu_resp_valid && !bus_req_valid && !snp_shared_out, "R1", "idle outputs",
            64'({cpu_resp_valid, bus_req_valid, snp_shared_out}), 64'd0);
        chk(cpu_req_ready, "R1", "ready after reset", 64'(cpu_req_ready), 64'd1);
        snoop_op(1'b0, 16'h0000, 32'h0, 1'b0);  // R1 address 0 not resident

        cpu_op(1'b0, 16'h0010, 32'h0, 1'b0, 0, "R2");          // fill, exclusive
        cpu_op(1'b0, 16'h0013, 32'h0, 1'b0, 0, "R3");          // R12 offset alias hits
        cpu_op(1'b1, 16'h0011, 32'hA5A5_0001, 1'b0, 0, "R4");  // exclusive -> modified
        cpu_op(1'b1, 16'h0012, 32'hA5A5_0002, 1'b0, 0, "R4");  // modified stays
        snoop_op(1'b0, 16'h0011, 32'h0, 1'b0);                 // R9 supply, -> shared
        cpu_op(1'b1, 16'h0010, 32'hB0B0_0003, 1'b1, 2, "R5");  // update, stays shared
        cpu_op(1'b1, 16'h0010, 32'hB0B0_0004, 1'b0, 1, "R5");  // update, -> exclusive
        cpu_op(1'b1, 16'h0010, 32'hB0B0_0005, 1'b0, 0, "R4");  // no bus, -> modified
        cpu_op(1'b0, 16'h0020, 32'h0, 1'b1, 1, "R7");          // write-back then fill
        snoop_op(1'b1, 16'h0022, 32'hC3C3_0006, 1'b0);         // R10 overwrite
        cpu_op(1'b0, 16'h0020, 32'h0, 1'b0, 0, "R10");
        cpu_op(1'b1, 16'h0030, 32'hD0D0_0007, 1'b0, 0, "R6");  // write miss -> modified
        snoop_op(1'b1, 16'h0040, 32'hEEEE_0008, 1'b0);         // R8 non-matching
        cpu_op(1'b0, 16'h0030, 32'h0, 1'b0, 0, "R8");
        cpu_op(1'b1, 16'h0050, 32'hD0D0_0009, 1'b1, 0, "R7");  // write-back then update, -> shared
        cpu_op(1'b0, 16'h0060, 32'h0, 1'b0, 0, "R2");          // exclusive
        snoop_op(1'b0, 16'h0060, 32'h0, 1'b0);                 // R10 exclusive -> shared
        cpu_op(1'b1, 16'h0060, 32'h1111_000A, 1'b1, 0, "R10"); // proves shared
        snoop_op(1'b0, 16'h0060, 32'h0, 1'b1);                 // R11 collision

        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            int            r = $urandom_range(0, 9);
            logic [AW-1:0] a = 16'(16'h0040 + 4 * $urandom_range(0, 3) + $urandom_range(0, 3));
            logic [DW-1:0] d = $urandom;
            if (r < 4)      cpu_op(1'b0, a, d, 1'($urandom_range(0, 1)), $urandom_range(0, 2), "R2");
            else if (r < 7) cpu_op(1'b1, a, d, 1'($urandom_range(0, 1)), $urandom_range(0, 2), "R6");
            else            snoop_op(1'($urandom_range(0, 1)), a, d, 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule